// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Hub

The hub lets every core of a small multiprocessor ring a doorbell on any other core and hand it a 16-bit message at the same moment. Each core has a slot with two 32-bit words on a simple register bus: a command word it writes and a mailbox word it reads. Writing the command word can post a message to a target core, clear the writer's own pending doorbell, or do both. Each core also has one interrupt line, which is high while its mailbox holds an unacknowledged message.

Each slot takes 8 bytes of address space. Address bit 2 picks the word within the slot and the address bits from bit 3 upward pick the core. A post from core S to core D overwrites D's mailbox with S's index and the payload, so a newer post replaces an older one. The number of cores and the address width are parameters.

Top module: `ipi_hub`

## Requirements
- R1: After reset every command word and mailbox word reads as zero and every interrupt line is low.
- R2: A write with address bit 2 = 0 stores the full 32-bit word in the command word of the core given by address bits [ADDR_W-1:3]. A read of that address returns the word unchanged.
- R3: A command write with bit 30 set posts to the destination core named in bits 29:16. From the next cycle that core's mailbox reads {bit31=0, bit30=1, bits29:16=writer index, bits15:0=written bits15:0} and its interrupt line is high.
- R4: A command write with bit 31 set clears bit 30 of the writer's own mailbox and drops the writer's interrupt line on the next cycle. Mailbox bits 29:0 keep their values.
- R5: When bits 31 and 30 are both set in one write, the post is applied first and the clear second. A core that posts to itself this way ends with bit 30 clear and its line low, with the sender and payload fields updated.
- R6: Writes with address bit 2 = 1 (mailbox words) change no register.
- R7: Accesses whose core index is at or above NUM_CORES are ignored. Writes change nothing and reads return zero.
- R8: A post whose destination ID is at or above NUM_CORES changes no mailbox. The command word is still stored, and the clear in bit 31 still acts.
- R9: Each interrupt line is a registered level equal to bit 30 of that core's mailbox.
- R10: A post to a core that already has a message pending overwrites its whole mailbox with the newer sender and payload.
- R11: Read data is zero whenever the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read enable; read data is combinational |
| bus_addr | input | ADDR_W | Byte address: bit 2 selects the word, bits [ADDR_W-1:3] select the core |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_out | output | NUM_CORES | One doorbell interrupt line per core |

## Verification
The hardest case to reach is a single write that both posts and clears. Its result depends on the order of the two actions, and it differs for a self-post and for a post to another core. The stimulus table first builds up pending messages on several cores. It then issues combined post-and-clear writes, once with the writer as its own destination and once aimed at a different core, and reads back the mailboxes of both the writer and the target. Out-of-range core indices and destination IDs are sent while other cores still hold messages, so any stray update shows up in the surviving mailboxes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int REG_W         = 32;
  localparam int ID_W          = 14;
  localparam int MSG_W         = 16;
  localparam int CTRL_ACK_BIT  = 31;
  localparam int CTRL_GEN_BIT  = 30;
  localparam int STAT_PEND_BIT = 30;
  localparam int DEST_LSB      = 16;

  typedef enum logic {
    WORD_CMD  = 1'b0,
    WORD_MBOX = 1'b1
  } word_sel_e;

  // destination core ID carried in a command word
  function automatic logic [ID_W-1:0] cmd_dest(input logic [REG_W-1:0] w);
    return w[DEST_LSB +: ID_W];
  endfunction

  // payload carried in a command word
  function automatic logic [MSG_W-1:0] cmd_msg(input logic [REG_W-1:0] w);
    return w[MSG_W-1:0];
  endfunction

  // mailbox image left at the destination by a post
  function automatic logic [REG_W-1:0] mbox_image(input logic [ID_W-1:0] src,
                                                  input logic [MSG_W-1:0] msg);
    return {1'b0, 1'b1, src, msg};
  endfunction

  // mailbox with its pending flag removed
  function automatic logic [REG_W-1:0] mbox_cleared(input logic [REG_W-1:0] s);
    logic [REG_W-1:0] r;
    r = s;
    r[STAT_PEND_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  core_idx,
  output logic              idx_ok,
  output word_sel_e         word_sel
);

  localparam logic [IDX_W:0] CORE_LIM = (IDX_W+1)'(NUM_CORES);

  logic [1:0] unused_low;

  always_comb begin
    core_idx   = addr[ADDR_W-1:3];
    word_sel   = word_sel_e'(addr[2]);
    idx_ok     = ({1'b0, core_idx} < CORE_LIM);
    unused_low = addr[1:0];
  end

endmodule

// File: rtl/ipi_cmd_route.sv
module ipi_cmd_route
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = ADDR_W - 3
) (
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     core_idx,
  input  logic                 idx_ok,
  input  word_sel_e            word_sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_CORES-1:0] cmd_wr_vec,
  output logic [NUM_CORES-1:0] gen_vec,
  output logic [NUM_CORES-1:0] ack_vec,
  output logic [REG_W-1:0]     post_word
);

  localparam logic [ID_W:0] DEST_LIM = (ID_W+1)'(NUM_CORES);

  logic            cmd_wr;
  logic            want_gen;
  logic            want_ack;
  logic [ID_W-1:0] dest_id;
  logic            dest_ok;

  always_comb begin
    cmd_wr    = wr_en && idx_ok && (word_sel == WORD_CMD);
    want_gen  = cmd_wr && wdata[CTRL_GEN_BIT];
    want_ack  = cmd_wr && wdata[CTRL_ACK_BIT];
    dest_id   = cmd_dest(wdata);
    dest_ok   = ({1'b0, dest_id} < DEST_LIM);
    post_word = mbox_image(ID_W'(core_idx), cmd_msg(wdata));
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_route
    always_comb begin
      cmd_wr_vec[i] = cmd_wr && (core_idx == IDX_W'(i));
      gen_vec[i]    = want_gen && dest_ok && (dest_id == ID_W'(i));
      ack_vec[i]    = want_ack && (core_idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             gen_hit,
  input  logic             ack_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] post_word,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] mbox_q,
  output logic             irq_q
);

  logic [REG_W-1:0] mbox_nxt;

  // post is applied before clear
  always_comb begin
    mbox_nxt = mbox_q;
    if (gen_hit) mbox_nxt = post_word;
    if (ack_hit) mbox_nxt = mbox_cleared(mbox_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mbox_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      mbox_q <= mbox_nxt;
      irq_q  <= mbox_nxt[STAT_PEND_BIT];
    end
  end

endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = ADDR_W - 3
) (
  input  logic                            rd_en,
  input  logic [IDX_W-1:0]                core_idx,
  input  logic                            idx_ok,
  input  word_sel_e                       word_sel,
  input  logic [NUM_CORES-1:0][REG_W-1:0] cmd_q,
  input  logic [NUM_CORES-1:0][REG_W-1:0] mbox_q,
  output logic [REG_W-1:0]                rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en && idx_ok) begin
      for (int i = 0; i < NUM_CORES; i++) begin
        if (core_idx == IDX_W'(i))
          rdata = (word_sel == WORD_CMD) ? cmd_q[i] : mbox_q[i];
      end
    end
  end

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq_out
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]                core_idx;
  logic                            idx_ok;
  word_sel_e                       word_sel;
  logic [NUM_CORES-1:0]            cmd_wr_vec;
  logic [NUM_CORES-1:0]            gen_vec;
  logic [NUM_CORES-1:0]            ack_vec;
  logic [REG_W-1:0]                post_word;
  logic [NUM_CORES-1:0][REG_W-1:0] cmd_q;
  logic [NUM_CORES-1:0][REG_W-1:0] mbox_q;

  ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .core_idx (core_idx),
    .idx_ok   (idx_ok),
    .word_sel (word_sel)
  );

  ipi_cmd_route #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_route (
    .wr_en      (bus_wr_en),
    .core_idx   (core_idx),
    .idx_ok     (idx_ok),
    .word_sel   (word_sel),
    .wdata      (bus_wdata),
    .cmd_wr_vec (cmd_wr_vec),
    .gen_vec    (gen_vec),
    .ack_vec    (ack_vec),
    .post_word  (post_word)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
    ipi_core_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr_vec[i]),
      .gen_hit   (gen_vec[i]),
      .ack_hit   (ack_vec[i]),
      .wdata     (bus_wdata),
      .post_word (post_word),
      .cmd_q     (cmd_q[i]),
      .mbox_q    (mbox_q[i]),
      .irq_q     (irq_out[i])
    );
  end

  ipi_read_mux #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_rd (
    .rd_en    (bus_rd_en),
    .core_idx (core_idx),
    .idx_ok   (idx_ok),
    .word_sel (word_sel),
    .cmd_q    (cmd_q),
    .mbox_q   (mbox_q),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/ipi_hub_checker.sv
module ipi_hub_checker
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_wr_en,
  input logic [31:0]                     bus_wdata,
  input logic [NUM_CORES-1:0]            irq_out,
  input logic                            idx_ok,
  input word_sel_e                       word_sel,
  input logic [NUM_CORES-1:0]            gen_vec,
  input logic [NUM_CORES-1:0]            ack_vec,
  input logic [NUM_CORES-1:0][REG_W-1:0] cmd_q,
  input logic [NUM_CORES-1:0][REG_W-1:0] mbox_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_out == '0));

  assert_single_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gen_vec));

  assert_status_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && word_sel == WORD_MBOX) |=> ($stable(mbox_q) && $stable(cmd_q)));

  assert_bad_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !idx_ok) |=> ($stable(mbox_q) && $stable(cmd_q)));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[i] == mbox_q[i][STAT_PEND_BIT]);

    assert_post_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_vec[i] && !ack_vec[i]) |=>
        (irq_out[i] && mbox_q[i][MSG_W-1:0] == $past(bus_wdata[MSG_W-1:0])));

    assert_clear_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vec[i] |=> !irq_out[i]);

    assert_clear_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vec[i] && !gen_vec[i]) |=> (mbox_q[i][29:0] == $past(mbox_q[i][29:0])));
  end

endmodule

bind ipi_hub ipi_hub_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .irq_out   (irq_out),
  .idx_ok    (idx_ok),
  .word_sel  (word_sel),
  .gen_vec   (gen_vec),
  .ack_vec   (ack_vec),
  .cmd_q     (cmd_q),
  .mbox_q    (mbox_q)
);

// File: tb/ipi_hub_bench.sv
module ipi_hub_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AW = 8;

  typedef struct packed {
    logic        we;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h0000_1234, 8'h00, 32'h0000_1234, 4'b0000, 8'd2},  // R2 plain store
    '{1'b1, 8'h00, 32'h4002_BEEF, 8'h14, 32'h4000_BEEF, 4'b0100, 8'd3},  // R3 core0 -> core2
    '{1'b1, 8'h08, 32'h4003_0055, 8'h1C, 32'h4001_0055, 4'b1100, 8'd3},  // R3 core1 -> core3
    '{1'b1, 8'h18, 32'h4002_AAAA, 8'h14, 32'h4003_AAAA, 4'b1100, 8'd10}, // R10 overwrite core2
    '{1'b1, 8'h10, 32'h8000_0000, 8'h14, 32'h0003_AAAA, 4'b1000, 8'd4},  // R4 core2 clears
    '{1'b1, 8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'h4001_0055, 4'b1000, 8'd6},  // R6 mailbox write
    '{1'b1, 8'h08, 32'hC001_0777, 8'h0C, 32'h0001_0777, 4'b1000, 8'd5},  // R5 self post+clear
    '{1'b1, 8'h18, 32'hC000_0123, 8'h04, 32'h4003_0123, 4'b0001, 8'd5},  // R5 post to 0, clear 3
    '{1'b0, 8'h00, 32'h0000_0000, 8'h1C, 32'h0001_0055, 4'b0001, 8'd4},  // R4 fields kept
    '{1'b1, 8'h00, 32'h4009_1111, 8'h00, 32'h4009_1111, 4'b0001, 8'd8},  // R8 bad destination
    '{1'b0, 8'h00, 32'h0000_0000, 8'h18, 32'hC000_0123, 4'b0001, 8'd2},  // R2 full word kept
    '{1'b1, 8'h20, 32'h4001_9999, 8'h0C, 32'h0001_0777, 4'b0001, 8'd7},  // R7 write core 4
    '{1'b0, 8'h00, 32'h0000_0000, 8'h20, 32'h0000_0000, 4'b0001, 8'd7},  // R7 read core 4
    '{1'b0, 8'h00, 32'h0000_0000, 8'h24, 32'h0000_0000, 4'b0001, 8'd7},  // R7 read core 4 mbox
    '{1'b1, 8'h00, 32'h8000_0000, 8'h04, 32'h0003_0123, 4'b0000, 8'd4}   // R4 core0 clears
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_hub #(.NUM_CORES(NC), .ADDR_W(AW)) u_ipi_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // one write cycle, driven at the falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b0;
    bus_wr_en = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  // sets up a read away from the clock edge and returns the data
  task automatic bus_read(input logic [7:0] a, input logic en, output logic [31:0] d);
    bus_wr_en = 1'b0;
    bus_rd_en = en;
    bus_addr  = a;
    #1;
    d = bus_rdata;
    bus_rd_en = 1'b0;
  endtask

  initial begin : main
    logic [31:0] rd;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every word zero and all lines low after reset
    for (int a = 0; a < 2*NC; a++) begin
      bus_read(8'(a*4), 1'b1, rd);
      check(1, "reset word", rd, 32'h0);
    end
    check(1, "reset irq", 32'(irq_out), 32'h0);

    // stimulus table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].we) bus_write(VECS[v].waddr, VECS[v].wdata);
      else @(negedge clk);
      bus_read(VECS[v].raddr, 1'b1, rd);
      check(int'(VECS[v].req), $sformatf("vector %0d read", v), rd, VECS[v].exp_rd);
      // R9: lines follow the pending flags
      check(9, $sformatf("vector %0d irq", v), 32'(irq_out), 32'(VECS[v].exp_irq));
    end

    // R11: read enable low gives zero even on a stored word
    @(negedge clk);
    bus_read(8'h18, 1'b0, rd);
    check(11, "read disabled", rd, 32'h0);
    bus_read(8'h18, 1'b1, rd);
    check(11, "read enabled", rd, 32'hC000_0123);

    // R8: bad destination still performs the clear of the writer
    bus_write(8'h08, 32'h4001_0042);      // core1 -> core1 pending
    check(3, "self post irq", 32'(irq_out), 32'h2);
    bus_write(8'h08, 32'hC00F_3333);      // post to core 15, clear core1
    bus_read(8'h0C, 1'b1, rd);
    check(8, "clear with bad dest", rd, 32'h0001_0042);
    check(8, "irq after bad dest", 32'(irq_out), 32'h0);

    // R1: reset in the middle of activity
    bus_write(8'h00, 32'h4003_5A5A);
    check(3, "post before reset", 32'(irq_out), 32'h8);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 2*NC; a++) begin
      bus_read(8'(a*4), 1'b1, rd);
      check(1, "word after reset", rd, 32'h0);
    end
    check(1, "irq after reset", 32'(irq_out), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule